// File: doc/BRIEF.md
# Modem Status Tracker

This block keeps the modem status byte of a 16450-style serial port. Four external handshake lines (carrier detect, ring indicator, data set ready, clear to send) pass through a two-flop synchroniser. Whenever the synchronised levels differ from the stored levels, the block takes a new sample. It records a change bit for each line that moved and raises a modem-change flag for the interrupt logic.

The register block reads the status byte through this block. A read in normal mode returns the stored byte, and the change bits clear afterwards. With the loopback bit of the modem control value set, a read instead returns the modem control outputs rearranged onto the status bit positions, and the stored change bits are left alone. The flag is cleared by the interrupt-identification read strobe from the register block. The ready-to-send and data-terminal-ready pins follow the modem control value directly.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset the status byte reads 0xB0, the modem-change flag is low, and `rts_o` and `dtr_o` are low while `mctl_i` is zero.
- R2: `line_in` carries {DCD, RI, DSR, CTS} on bits 3..0. Their stored levels appear on status bits 7, 6, 5 and 4, three clock edges after the input changes (two synchroniser flops, then the store).
- R3: A new sample sets change bit 3 (DCD), bit 1 (DSR) or bit 0 (CTS) for each of those lines whose new level differs from the stored level.
- R4: Status bit 2 is set only when RI was stored high and the new sample is low. A rising RI sets no change bit.
- R5: Every new sample sets `mchg_o`. Synchronised levels equal to the stored levels take no sample and leave the flag and the byte unchanged.
- R6: A status read with `mctl_i[4]` low returns the stored byte in the cycle of the strobe. Bits 3..0 are zero afterwards, and bits 7..4 are kept.
- R7: A pulse on `iid_rd_i` clears `mchg_o` at the next edge, unless a new sample is taken in the same cycle.
- R8: A set change bit stays set until a normal-mode read, even when its line returns to the earlier level.
- R9: With `mctl_i[4]` high, the read value is bit 7 = `mctl_i[3]`, bit 6 = `mctl_i[2]`, bit 5 = `mctl_i[0]`, bit 4 = `mctl_i[1]`, and bits 3..0 are zero.
- R10: A read in loopback leaves the stored change bits untouched. They show up on the first normal-mode read after leaving loopback.
- R11: `rts_o` equals `mctl_i[1]` and `dtr_o` equals `mctl_i[0]`.
- R12: When a normal-mode read and a new sample fall in the same cycle, the read returns the pre-sample byte. Afterwards the change bits hold exactly the changes of that sample.
- R13: When `iid_rd_i` and a new sample fall in the same cycle, `mchg_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_in | input | 4 | Raw handshake inputs {DCD, RI, DSR, CTS} |
| mctl_i | input | 5 | Modem control value: [4] loopback, [3] OUT2, [2] OUT1, [1] RTS, [0] DTR |
| stat_rd_i | input | 1 | One-cycle strobe: host read of the status address |
| iid_rd_i | input | 1 | One-cycle strobe: host read of the interrupt-identification address |
| stat_rdata_o | output | 8 | Status value for the current read |
| mchg_o | output | 1 | Modem-change flag for the interrupt logic |
| rts_o | output | 1 | Ready-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |

## Verification
A new sample can land in the same cycle as the clearing status read, and separately in the same cycle as the interrupt-identification read. The bench provokes each case by changing a line and placing the strobe on the second falling edge after the change, so that the strobe is high across the store edge. In the read case it expects the pre-sample byte and then only the fresh change bit. In the other case it requires the flag to survive.

// File: rtl/mst_pkg.sv
`timescale 1ns/1ps
package mst_pkg;
  localparam int LINES = 4;
  localparam int STAT_W = 2 * LINES;
  localparam int MC_W = 5;

  // line index positions (shared by level and change nibbles)
  localparam int LN_DCD = 3;
  localparam int LN_RI  = 2;
  localparam int LN_DSR = 1;
  localparam int LN_CTS = 0;

  // modem control positions
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;

  typedef logic [LINES-1:0] lines_t;
  typedef logic [MC_W-1:0]  mctl_t;

  typedef struct packed {
    lines_t lvl;
    lines_t dlt;
  } stat_t;

  localparam lines_t LVL_RST = 4'b1011;

  function automatic lines_t change_set(input lines_t old_l, input lines_t new_l);
    lines_t s;
    s         = old_l ^ new_l;
    s[LN_RI]  = old_l[LN_RI] & ~new_l[LN_RI];
    return s;
  endfunction

  function automatic logic [STAT_W-1:0] loop_view(input mctl_t mc);
    logic [STAT_W-1:0] v;
    v                   = '0;
    v[LINES + LN_DCD]   = mc[MC_OUT2];
    v[LINES + LN_RI]    = mc[MC_OUT1];
    v[LINES + LN_DSR]   = mc[MC_DTR];
    v[LINES + LN_CTS]   = mc[MC_RTS];
    return v;
  endfunction
endpackage

// File: rtl/mst_sync.sv
`timescale 1ns/1ps
module mst_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_n;

    always_comb begin
      chain_n = {chain_q[STAGES-2:0], din[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_n;
    end

    assign dout[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mst_change_det.sv
`timescale 1ns/1ps
module mst_change_det
  import mst_pkg::*;
(
  input  lines_t sampled,
  input  lines_t stored,
  output logic   take,
  output lines_t set_bits
);
  always_comb begin
    take     = |(sampled ^ stored);
    set_bits = take ? change_set(stored, sampled) : '0;
  end
endmodule

// File: rtl/mst_status_reg.sv
`timescale 1ns/1ps
module mst_status_reg
  import mst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  lines_t sampled,
  input  lines_t set_bits,
  input  logic   rd,
  input  logic   loop,
  input  logic   iid_rd,
  output stat_t  stat,
  output logic   mchg
);
  stat_t stat_n;
  logic  mchg_n;
  logic  clr;

  always_comb begin
    clr        = rd & ~loop;
    stat_n.lvl = take ? sampled : stat.lvl;
    stat_n.dlt = (clr ? '0 : stat.dlt) | set_bits;
    if (take)        mchg_n = 1'b1;
    else if (iid_rd) mchg_n = 1'b0;
    else             mchg_n = mchg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat.lvl <= LVL_RST;
      stat.dlt <= '0;
      mchg     <= 1'b0;
    end else begin
      stat <= stat_n;
      mchg <= mchg_n;
    end
  end

  // R5
  upd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mchg);
  // R5
  quiet_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(stat.lvl));
  // R7
  iid_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && !take) |=> !mchg);
  // R6
  read_clears_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !loop && !take) |=> (stat.dlt == '0));
  // R10
  loop_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && loop && !take) |=> $stable(stat));
  // R8
  delta_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && !loop) |=> ((stat.dlt & $past(stat.dlt)) == $past(stat.dlt)));
  // R12
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !loop && take) |=> (stat.dlt == $past(set_bits)));
endmodule

// File: rtl/modem_status_tracker.sv
`timescale 1ns/1ps
module modem_status_tracker
  import mst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] line_in,
  input  logic [4:0] mctl_i,
  input  logic       stat_rd_i,
  input  logic       iid_rd_i,
  output logic [7:0] stat_rdata_o,
  output logic       mchg_o,
  output logic       rts_o,
  output logic       dtr_o
);
  lines_t sampled;
  lines_t set_bits;
  logic   take;
  stat_t  stat;
  logic   loop;

  assign loop = mctl_i[MC_LOOP];

  mst_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_in),
    .dout (sampled)
  );

  mst_change_det u_det (
    .sampled (sampled),
    .stored  (stat.lvl),
    .take    (take),
    .set_bits(set_bits)
  );

  mst_status_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .sampled (sampled),
    .set_bits(set_bits),
    .rd      (stat_rd_i),
    .loop    (loop),
    .iid_rd  (iid_rd_i),
    .stat    (stat),
    .mchg    (mchg_o)
  );

  always_comb begin
    stat_rdata_o = loop ? loop_view(mctl_i) : stat;
  end

  assign rts_o = mctl_i[MC_RTS];
  assign dtr_o = mctl_i[MC_DTR];

  // R13
  iid_collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd_i && take) |=> mchg_o);
endmodule

// File: tb/tb_modem_status_tracker.sv
`timescale 1ns/1ps
module tb_modem_status_tracker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] line_in;
  logic [4:0] mctl_i;
  logic       stat_rd_i;
  logic       iid_rd_i;
  logic [7:0] stat_rdata_o;
  logic       mchg_o, rts_o, dtr_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  // reference model state
  logic [3:0] m_lv, m_dl;
  logic       m_chg;

  always #4 clk = ~clk;

  modem_status_tracker dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .mctl_i(mctl_i),
    .stat_rd_i(stat_rd_i), .iid_rd_i(iid_rd_i), .stat_rdata_o(stat_rdata_o),
    .mchg_o(mchg_o), .rts_o(rts_o), .dtr_o(dtr_o)
  );

  function automatic logic [3:0] m_set(input logic [3:0] o, input logic [3:0] n);
    return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
  endfunction

  function automatic logic [7:0] m_loop(input logic [4:0] mc);
    return {mc[3], mc[2], mc[0], mc[1], 4'b0000};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: compare every read strobe against the queued expectation
  initial begin
    logic [7:0] e;
    string      r;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n === 1'b1 && stat_rd_i === 1'b1) begin
        if (exp_q.size() == 0) begin
          check("unexpected read", stat_rdata_o, 8'h00);
        end else begin
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(r, stat_rdata_o, e);
        end
      end
    end
  end

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    line_in = v;
    repeat (3) @(negedge clk);
    if (v != m_lv) begin
      m_dl  = m_dl | m_set(m_lv, v);
      m_lv  = v;
      m_chg = 1'b1;
    end
  endtask

  task automatic host_read(input string req);
    @(negedge clk);
    exp_q.push_back(mctl_i[4] ? m_loop(mctl_i) : {m_lv, m_dl});
    req_q.push_back(req);
    stat_rd_i = 1'b1;
    @(negedge clk);
    stat_rd_i = 1'b0;
    if (!mctl_i[4]) m_dl = '0;
  endtask

  task automatic iid_read();
    @(negedge clk);
    iid_rd_i = 1'b1;
    @(negedge clk);
    iid_rd_i = 1'b0;
    m_chg = 1'b0;
  endtask

  task automatic set_mctl(input logic [4:0] v);
    @(negedge clk);
    mctl_i = v;
    #2;
    check("R11 rts", {7'd0, rts_o}, {7'd0, v[1]});
    check("R11 dtr", {7'd0, dtr_o}, {7'd0, v[0]});
  endtask

  task automatic check_flag(input string req);
    @(negedge clk);
    #2;
    check(req, {7'd0, mchg_o}, {7'd0, m_chg});
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; line_in = 4'b1011; mctl_i = '0; stat_rd_i = 1'b0; iid_rd_i = 1'b0;
    m_lv = 4'b1011; m_dl = '0; m_chg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    check("R1 status", stat_rdata_o, 8'hB0);
    check("R1 flag", {7'd0, mchg_o}, 8'h00);
    check("R1 rts/dtr", {6'd0, rts_o, dtr_o}, 8'h00);
    host_read("R1 read");

    // R2 R3: CTS drops, latency three edges
    @(negedge clk);
    line_in = 4'b1010;
    @(negedge clk); @(negedge clk);
    #2 check("R2 not before third edge", stat_rdata_o, 8'hB0);
    @(negedge clk);
    m_dl = m_set(m_lv, 4'b1010); m_lv = 4'b1010; m_chg = 1'b1;
    #2 check("R2 R3 cts change", stat_rdata_o, 8'hA1);
    check_flag("R5 flag set");
    host_read("R6 read returns byte");
    host_read("R6 deltas cleared, levels kept");

    // R7 flag clear by interrupt-id read
    iid_read();
    check_flag("R7 flag cleared");
    // R5 identical levels take no sample
    set_pins(4'b1010);
    check_flag("R5 no sample on same level");
    host_read("R5 byte unchanged");

    // R4 RI rising then falling
    set_pins(4'b1110);
    host_read("R4 rising RI no change bit");
    set_pins(4'b1010);
    host_read("R4 trailing RI sets bit 2");

    // R8 sticky: DSR toggles away and back
    set_pins(4'b1000);
    set_pins(4'b1010);
    host_read("R8 sticky DSR change");
    host_read("R8 cleared after read");

    // R9 R10 loopback
    set_pins(4'b0010);
    set_mctl(5'b10110);
    host_read("R9 loop view 50");
    set_mctl(5'b11001);
    host_read("R9 loop view A0");
    host_read("R10 loop read repeat");
    set_mctl(5'b00000);
    host_read("R10 change kept through loop");
    host_read("R6 cleared after normal read");

    // R12 read collides with a new sample
    set_pins(4'b1010);
    @(negedge clk);
    line_in = 4'b1011;
    @(negedge clk);
    @(negedge clk);
    exp_q.push_back({m_lv, m_dl});
    req_q.push_back("R12 collide returns old byte");
    stat_rd_i = 1'b1;
    @(negedge clk);
    stat_rd_i = 1'b0;
    m_dl = m_set(m_lv, 4'b1011); m_lv = 4'b1011; m_chg = 1'b1;
    host_read("R12 only fresh change kept");

    // R13 interrupt-id read collides with a new sample
    iid_read();
    check_flag("R7 flag clear before collide");
    @(negedge clk);
    line_in = 4'b1001;
    @(negedge clk);
    @(negedge clk);
    iid_rd_i = 1'b1;
    @(negedge clk);
    iid_rd_i = 1'b0;
    m_dl = m_dl | m_set(m_lv, 4'b1001); m_lv = 4'b1001; m_chg = 1'b1;
    check_flag("R13 flag survives");
    host_read("R13 byte after collide");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("queue drained", 8'(exp_q.size()), 8'h00);
    summary();
    $finish;
  end
endmodule